// File: doc/BRIEF.md
# Receive Entry Buffer with Switchable Depth

This block is the receive-side store of a serial port. A line receiver hands it 12-bit entries, each an 8-bit character in bits 7:0 plus a 4-bit error nibble in bits 11:8. A bus-side reader takes them out in arrival order by pulsing a pop request. The pop presents the head entry on the data output in the same cycle. The error nibble of the entry taken is latched into a small status register, which the bus can clear. The store runs either as a 16-deep queue or as a single holding slot. The depth follows a mode input that stands for the FIFO-enable bit of the line control register.

Changing the mode at run time discards everything held and restarts both pointers. A detected line break enters the queue as the fixed entry 0x400, where only bit 10 is set. The block drives a flag byte with the receive full and empty bits and the transmit bits in their idle form. It also drives a ready signal for the line receiver and one-cycle pulses that raise and drop the receive-level interrupt. That interrupt triggers at a level of one entry.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the flag byte is 0x90, `can_accept` is 1, `rx_status` is 0 and both level pulses are 0. The block starts in single-slot mode, with `fifo_en` read as 0.
- R2: When the registered mode is 1, the queue holds 16 entries. Flag bit 6 (full) is 1 exactly when 16 are held, and flag bit 4 (empty) is 1 exactly when none are held.
- R3: Flag bit 7 is always 1. Flag bit 5 and flag bits 3:0 are always 0.
- R4: When the registered mode is 0, the store holds one entry. Holding it sets flag bit 6, and a further push is dropped.
- R5: While `pop_req` is high, `pop_word` shows the entry at the read slot in that same cycle. A pop removes that entry only if the store is non-empty. A pop on an empty store changes neither the occupancy nor the flags.
- R6: A pop loads `pop_word[11:8]` into `rx_status` at the clock edge. Otherwise `status_clr` zeroes it, and a pop wins over a clear in the same cycle.
- R7: A cycle where `fifo_en` differs from the registered mode is a flush. The mode takes the new value, all held entries are discarded, and any push or pop in that cycle is ignored.
- R8: `brk_req` pushes the entry 0x400. It takes priority over `push_req` in the same cycle, and the data word is then dropped.
- R9: `rx_lvl_set` pulses for one cycle after a clock edge that takes the occupancy from 0 to 1. `rx_lvl_clr` pulses for one cycle after a pop takes it from 1 to 0. A flush raises neither.
- R10: A push and a pop of a non-empty store in the same cycle leave the occupancy unchanged. Arrival order is preserved.
- R11: A push is accepted only while the occupancy is below the current depth, even if a pop occurs in the same cycle. `can_accept` reports exactly this, and it is 0 during a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | Requested mode: 1 for 16-deep, 0 for single slot |
| push_req | input | 1 | Line receiver offers `push_word` |
| push_word | input | 12 | Error nibble in bits 11:8, character in bits 7:0 |
| brk_req | input | 1 | Line break detected; pushes 0x400 |
| pop_req | input | 1 | Bus reads the data register |
| status_clr | input | 1 | Bus clears the receive status register |
| pop_word | output | 12 | Entry at the read slot |
| rx_status | output | 4 | Error nibble of the last entry popped |
| flags | output | 8 | Bit 7 TX empty, 6 RX full, 5 TX full, 4 RX empty |
| can_accept | output | 1 | A push in this cycle would be stored |
| rx_lvl_set | output | 1 | Pulse: receive-level interrupt raised |
| rx_lvl_clr | output | 1 | Pulse: receive-level interrupt dropped |

## Verification
Some properties are checked on every cycle. The transmit bits stay fixed, and the full and empty bits are never both set. A full store never offers to accept. A flush always leaves the store empty. A pop always latches the shown nibble. Single-slot mode is never non-empty without being full, and the set pulse never coincides with an empty store. Only the bench scenarios can show the rest. These are the order of entries through a wrap, dropped pushes when full, the break entry winning over data, the status clear priority, and the stale value seen on an empty pop. They also include the exact cycle of each level pulse.

// File: rtl/rxq_pkg.sv
// Shared constants and types for the receive entry buffer.
// Assumes 12-bit entries: error nibble in 11:8, character in 7:0.
package rxq_pkg;

    localparam int ENTRY_W = 12;
    localparam int NIB_W   = 4;

    typedef logic [ENTRY_W-1:0] rxq_entry_t;

    // Entry stored when the line receiver reports a break condition.
    localparam rxq_entry_t BREAK_ENTRY = 12'h400;

    // Bit positions inside the flag byte; software decodes these.
    localparam int FLG_TX_EMPTY = 7;
    localparam int FLG_RX_FULL  = 6;
    localparam int FLG_TX_FULL  = 5;
    localparam int FLG_RX_EMPTY = 4;

endpackage

// File: rtl/rxq_store.sv
// Entry storage: one write port, one combinational read port.
// Assumes the controller never writes a slot that holds unread data.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  rxq_entry_t       wr_data,
    input  logic [AW-1:0]    rd_idx,
    output rxq_entry_t       rd_data
);

    rxq_entry_t slots [DEPTH];

    // Write the addressed slot; clear all slots on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    // Present the entry at the read slot.
    always_comb begin
        rd_data = slots[rd_idx];
    end

endmodule

// File: rtl/rxq_ctrl.sv
// Pointer and occupancy control for the receive buffer.
// The depth is DEPTH in queue mode and 1 in single-slot mode. A change of
// the requested mode flushes the store and ignores traffic in that cycle.
module rxq_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push_any,
    input  logic          pop_req,
    output logic          mode_q,
    output logic          flush,
    output logic          room,
    output logic          full,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] wr_idx,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] MASK_Q  = AW'(DEPTH - 1);

    logic [CW-1:0] cur_depth;
    logic [AW-1:0] mask;
    logic          pop_adv;
    logic [AW-1:0] rd_nxt;

    // Derive the current depth, pointer mask and the accepted operations.
    always_comb begin
        cur_depth = mode_q ? DEPTH_C : CW'(1);
        mask      = mode_q ? MASK_Q : '0;
        flush     = (fifo_en != mode_q);
        room      = (cnt < cur_depth);
        full      = (cnt == cur_depth);
        push_ok   = push_any && room && !flush;
        pop_ok    = pop_req && !flush;
        pop_adv   = pop_ok && (cnt != '0);
        wr_idx    = (rd_ptr + cnt[AW-1:0]) & mask;
        rd_nxt    = pop_adv ? ((rd_ptr + AW'(1)) & mask) : rd_ptr;
        if (flush) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt + CW'(push_ok) - CW'(pop_adv);
        end
    end

    // Register the mode, read pointer and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            mode_q <= fifo_en;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            rd_ptr <= rd_nxt;
            cnt    <= cnt_nxt;
        end
    end

endmodule

// File: rtl/rxq_flags.sv
// Flag byte, receive status nibble and receive-level interrupt pulses.
// Assumes cnt and cnt_nxt come from the controller in the same cycle.
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int CW   = 5,
    parameter int TRIG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cnt,
    input  logic [CW-1:0]    cnt_nxt,
    input  logic             full,
    input  logic             flush,
    input  logic             pop_ok,
    input  logic [NIB_W-1:0] pop_nib,
    input  logic             status_clr,
    output logic [7:0]       flags,
    output logic [NIB_W-1:0] rx_status,
    output logic             lvl_set,
    output logic             lvl_clr
);

    localparam logic [CW-1:0] TRIG_C = CW'(TRIG);
    localparam logic [CW-1:0] BELOW  = CW'(TRIG - 1);

    logic set_ev;
    logic clr_ev;

    // Build the flag byte; transmit bits sit in their idle state.
    always_comb begin
        flags               = '0;
        flags[FLG_TX_EMPTY] = 1'b1;
        flags[FLG_TX_FULL]  = 1'b0;
        flags[FLG_RX_FULL]  = full;
        flags[FLG_RX_EMPTY] = (cnt == '0);
    end

    // Detect occupancy crossing the trigger level in either direction.
    always_comb begin
        set_ev = !flush && (cnt == BELOW) && (cnt_nxt == TRIG_C);
        clr_ev = !flush && pop_ok && (cnt == TRIG_C) && (cnt_nxt == BELOW);
    end

    // Register the level pulses and the status nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_set   <= 1'b0;
            lvl_clr   <= 1'b0;
            rx_status <= '0;
        end else begin
            lvl_set <= set_ev;
            lvl_clr <= clr_ev;
            if (pop_ok) begin
                rx_status <= pop_nib;
            end else if (status_clr) begin
                rx_status <= '0;
            end
        end
    end

endmodule

// File: rtl/rxq_buffer.sv
// Top of the receive entry buffer: selects the pushed entry (break or
// data), ties controller, storage and flag logic together.
// Assumes the bus pops at most once per cycle and samples pop_word then.
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_en,
    input  logic        push_req,
    input  logic [11:0] push_word,
    input  logic        brk_req,
    input  logic        pop_req,
    input  logic        status_clr,
    output logic [11:0] pop_word,
    output logic [3:0]  rx_status,
    output logic [7:0]  flags,
    output logic        can_accept,
    output logic        rx_lvl_set,
    output logic        rx_lvl_clr
);

    logic          mode_q;
    logic          flush;
    logic          room;
    logic          full;
    logic          push_ok;
    logic          pop_ok;
    logic          push_any;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_idx;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    rxq_entry_t    in_entry;
    rxq_entry_t    head;

    // Choose the entry to push; a break outranks a data word.
    always_comb begin
        push_any = push_req || brk_req;
        in_entry = brk_req ? BREAK_ENTRY : push_word;
    end

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .push_any (push_any),
        .pop_req  (pop_req),
        .mode_q   (mode_q),
        .flush    (flush),
        .room     (room),
        .full     (full),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .rd_ptr   (rd_ptr),
        .wr_idx   (wr_idx),
        .cnt      (cnt),
        .cnt_nxt  (cnt_nxt)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_ok),
        .wr_idx  (wr_idx),
        .wr_data (in_entry),
        .rd_idx  (rd_ptr),
        .rd_data (head)
    );

    rxq_flags #(.CW(CW), .TRIG(TRIG)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt),
        .cnt_nxt    (cnt_nxt),
        .full       (full),
        .flush      (flush),
        .pop_ok     (pop_ok),
        .pop_nib    (head[11:8]),
        .status_clr (status_clr),
        .flags      (flags),
        .rx_status  (rx_status),
        .lvl_set    (rx_lvl_set),
        .lvl_clr    (rx_lvl_clr)
    );

    // Drive the bus-side data and the receiver-side ready.
    always_comb begin
        pop_word   = head;
        can_accept = room && !flush;
    end

endmodule

// File: rtl/rxq_buffer_chk.sv
// Cycle-by-cycle properties of the receive entry buffer, bound to the top.
module rxq_buffer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fifo_en,
    input logic        mode_q,
    input logic        pop_req,
    input logic [11:0] pop_word,
    input logic [3:0]  rx_status,
    input logic [7:0]  flags,
    input logic        can_accept,
    input logic        rx_lvl_set,
    input logic        rx_lvl_clr
);

    a_r3_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        flags[7] && !flags[5] && (flags[3:0] == 4'h0));

    a_r2_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags[6] && flags[4]));

    a_r11_full_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        flags[6] |-> !can_accept);

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != mode_q) |=> (flags[4] && !flags[6]));

    a_r6_status_load: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && (fifo_en == mode_q)) |=> (rx_status == $past(pop_word[11:8])));

    a_r4_single_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !flags[4]) |-> flags[6]);

    a_r9_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_lvl_set && rx_lvl_clr));

    a_r9_set_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lvl_set |-> !flags[4]);

endmodule

bind rxq_buffer rxq_buffer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .mode_q     (mode_q),
    .pop_req    (pop_req),
    .pop_word   (pop_word),
    .rx_status  (rx_status),
    .flags      (flags),
    .can_accept (can_accept),
    .rx_lvl_set (rx_lvl_set),
    .rx_lvl_clr (rx_lvl_clr)
);

// File: tb/rxq_buffer_test.sv
module rxq_buffer_test;

    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        push_req = 1'b0;
    logic [11:0] push_word = '0;
    logic        brk_req = 1'b0;
    logic        pop_req = 1'b0;
    logic        status_clr = 1'b0;
    logic [11:0] pop_word;
    logic [3:0]  rx_status;
    logic [7:0]  flags;
    logic        can_accept;
    logic        rx_lvl_set;
    logic        rx_lvl_clr;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model built from the requirements.
    logic [11:0] mq [$];
    logic        m_mode = 1'b0;
    logic [3:0]  m_stat = '0;
    bit          m_stat_known = 1'b1;
    bit          e_set = 1'b0;
    bit          e_clr = 1'b0;
    logic [11:0] last_pop;

    rxq_buffer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push_req   (push_req),
        .push_word  (push_word),
        .brk_req    (brk_req),
        .pop_req    (pop_req),
        .status_clr (status_clr),
        .pop_word   (pop_word),
        .rx_status  (rx_status),
        .flags      (flags),
        .can_accept (can_accept),
        .rx_lvl_set (rx_lvl_set),
        .rx_lvl_clr (rx_lvl_clr)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int m_dep();
        return m_mode ? 16 : 1;
    endfunction

    function automatic logic [7:0] m_flags();
        logic [7:0] f;
        f = 8'h80;
        if (mq.size() == m_dep()) f = f | 8'h40;
        if (mq.size() == 0)       f = f | 8'h10;
        return f;
    endfunction

    // One clock: drive at a falling edge, update the model, check after the rise.
    task automatic step(input bit pu, input logic [11:0] w, input bit br,
                        input bit po, input bit cl);
        int old_n;
        bit take;
        logic [11:0] hd;
        push_req = pu; push_word = w; brk_req = br; pop_req = po; status_clr = cl;
        #1;
        last_pop = pop_word;
        old_n = mq.size();
        e_set = 0; e_clr = 0;
        if (fifo_en !== m_mode) begin
            mq.delete();
            m_mode = fifo_en;
        end else begin
            take = po && (old_n > 0);
            hd = take ? mq[0] : 12'h000;
            if (take) chk("R5 pop head", last_pop, hd);
            if ((pu || br) && (old_n < m_dep())) mq.push_back(br ? 12'h400 : w);
            if (take) void'(mq.pop_front());
            if (po) begin
                m_stat = hd[11:8];
                m_stat_known = take;
            end else if (cl) begin
                m_stat = 4'h0;
                m_stat_known = 1'b1;
            end
            e_set = (old_n == 0) && (mq.size() == 1);
            e_clr = (old_n == 1) && (mq.size() == 0) && po;
        end
        @(negedge clk);
        push_req = 0; brk_req = 0; pop_req = 0; status_clr = 0;
        chk("R2 flags", flags, m_flags());
        chk("R11 can_accept", can_accept, (mq.size() < m_dep()));
        chk("R9 set pulse", rx_lvl_set, e_set);
        chk("R9 clr pulse", rx_lvl_clr, e_clr);
        if (m_stat_known) chk("R6 status", rx_status, m_stat);
    endtask

    task automatic t_reset();
        chk("R1 flags", flags, 8'h90);
        chk("R1 can_accept", can_accept, 1);
        chk("R1 status", rx_status, 0);
        chk("R1 pulses", {rx_lvl_set, rx_lvl_clr}, 0);
        chk("R3 tx bits", {flags[7], flags[5], flags[3:0]}, 6'b100000);
    endtask

    task automatic t_single();
        step(1, 12'h0A5, 0, 0, 0);
        chk("R4 full after one", flags[6], 1);
        step(1, 12'h0B6, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        chk("R4 second push dropped", last_pop, 12'h0A5);
        chk("R4 empty after pop", flags[4], 1);
    endtask

    task automatic t_fill16();
        fifo_en = 1;
        step(0, 0, 0, 0, 0);
        chk("R7 mode taken", flags, 8'h90);
        for (int i = 0; i < 16; i++) step(1, {4'(i), 8'(i * 13 + 1)}, 0, 0, 0);
        chk("R2 full at 16", flags[6], 1);
        chk("R11 no room", can_accept, 0);
        step(1, 12'hFFF, 0, 0, 0);
        for (int i = 0; i < 16; i++) begin
            step(0, 0, 0, 1, 0);
            chk("R10 order", last_pop, {4'(i), 8'(i * 13 + 1)});
        end
        chk("R2 empty at 0", flags[4], 1);
    endtask

    task automatic t_pushpop();
        step(1, 12'h111, 0, 0, 0);
        step(1, 12'h222, 0, 1, 0);
        chk("R10 count kept", flags, 8'h80);
        step(0, 0, 0, 1, 0);
        chk("R10 newer next", last_pop, 12'h222);
    endtask

    task automatic t_full_pushpop();
        for (int i = 0; i < 16; i++) step(1, 12'(i + 32), 0, 0, 0);
        step(1, 12'h7EE, 0, 1, 0);
        chk("R11 head popped", last_pop, 12'd32);
        chk("R11 one slot free", flags, 8'h80);
        for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 0);
        chk("R11 push while full dropped", last_pop, 12'd47);
        chk("R11 drained", flags[4], 1);
    endtask

    task automatic t_break();
        step(1, 12'h0C3, 1, 0, 0);
        step(0, 0, 0, 1, 0);
        chk("R8 break entry", last_pop, 12'h400);
        chk("R8 break nibble", rx_status, 4'h4);
        chk("R8 data dropped", flags[4], 1);
    endtask

    task automatic t_status();
        step(1, 12'h9AB, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        chk("R6 clear", rx_status, 0);
        step(0, 0, 0, 1, 1);
        chk("R6 pop beats clear", rx_status, 4'h9);
        step(0, 0, 0, 0, 1);
        chk("R6 clear again", rx_status, 0);
    endtask

    task automatic t_empty_pop();
        step(0, 0, 0, 1, 0);
        chk("R5 empty pop keeps flags", flags, 8'h90);
        chk("R5 empty pop no clr pulse", rx_lvl_clr, 0);
        step(0, 0, 0, 0, 1);
    endtask

    task automatic t_flush();
        step(1, 12'h301, 0, 0, 0);
        step(1, 12'h302, 0, 0, 0);
        step(1, 12'h303, 0, 0, 0);
        fifo_en = 0;
        step(1, 12'h3FF, 0, 1, 0);
        chk("R7 flushed", flags, 8'h90);
        chk("R7 no clr pulse", rx_lvl_clr, 0);
        step(1, 12'h055, 0, 0, 0);
        chk("R7 single depth now", flags, 8'hC0);
        step(0, 0, 0, 1, 0);
        chk("R7 fresh entry", last_pop, 12'h055);
    endtask

    initial begin
        #(CLK_PER * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single();
        t_empty_pop();
        t_fill16();
        t_pushpop();
        t_full_pushpop();
        t_break();
        t_status();
        t_flush();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule